// File: doc/BRIEF.md
# Power-good latched frequency selector

This block decides the host clock frequency once, at power-up. Board straps drive three select pins and a table-choice pin. An active-low power-good input is watched through a synchronizer. When power-good is first seen low on two consecutive clocks, the block freezes the synchronized strap values. From then on the block is locked and ignores every input until the next reset.

The frozen straps are decoded through one of two tables. A latched table-choice of 0 uses a table that reads all three select bits. A latched 1 uses a table that reads only the two low select bits. The block outputs a two-bit CPU rate code and a flag for selections the active table does not list. It also outputs the fixed companion rates as constant kHz values.

Top module: `pwrgd_freq_sel`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next state has `locked` = 0, `cpu_sel` = 0 and `cpu_reserved` = 0.
- R2: `pwrgd_n` and the four strap pins each pass through a two-flop synchronizer. A low on `pwrgd_n` that is sampled at only one rising edge never causes a capture. A low that is sampled at two consecutive edges does cause one.
- R3: Let `pwrgd_n` first be low at edges k and k+1. Then `locked` is 0 after edge k+2 and 1 after edge k+3. The captured straps are the pin values at edge k+1.
- R4: After `locked` is 1, changes on `pwrgd_n` and on every strap pin have no effect on any output until reset.
- R5: `cpu_sel` encodes the CPU rate as 0 = 100 MHz, 1 = 133 MHz, 2 = 200 MHz and 3 = 266 MHz.
- R6: With latched `tbl_sel` = 0, {fs_c,fs_b,fs_a} decodes as follows: 101 gives code 0, 001 gives code 1, 010 gives code 2 and 000 gives code 3.
- R7: With latched `tbl_sel` = 1, {fs_b,fs_a} decodes as follows: 00 gives code 0, 01 gives code 1 and 10 gives code 2. `fs_c` has no effect.
- R8: When locked, any selection the active table does not list sets `cpu_reserved` = 1 and `cpu_sel` = 0. For table 0 these are 111, 011, 100 and 110. For table 1 this is {fs_b,fs_a} = 11.
- R9: While `locked` is 0, `cpu_sel` = 0 and `cpu_reserved` = 0.
- R10: In every state the companion outputs are constant: `src_khz` = 100000, `pci_khz` = 33333, `ref_khz` = 14318 and `usb_khz` = 48000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwrgd_n | input | 1 | Active-low power-good, asynchronous |
| fs_a | input | 1 | Select strap, bit 0 |
| fs_b | input | 1 | Select strap, bit 1 |
| fs_c | input | 1 | Select strap, bit 2 |
| tbl_sel | input | 1 | Table choice strap (0 = three-bit table, 1 = two-bit table) |
| cpu_sel | output | 2 | Encoded CPU rate |
| cpu_reserved | output | 1 | Selection is not listed in the active table |
| locked | output | 1 | Capture has happened |
| src_khz | output | 17 | SRC rate in kHz |
| pci_khz | output | 17 | PCI rate in kHz |
| ref_khz | output | 17 | REF rate in kHz |
| usb_khz | output | 17 | USB rate in kHz |

## Verification
Two events can fall in the same cycle: the straps moving and the capture of the straps. They matter because the straps and power-good share one synchronizer delay. The bench drops power-good and then, right after the second sampling edge, switches every strap to its complement. The decoded result after lock must match the pre-switch straps, and `locked` must rise exactly at edge k+3. The bench also sweeps both tables over all eight select values, then toggles every input after lock and expects the outputs to stay frozen.

// File: rtl/fsel_pkg.sv
// Shared types and constants for the power-good latched frequency selector.
// Assumes: companion rates are fixed and reported in kHz.
package fsel_pkg;

    typedef enum logic [1:0] {
        CPU_100 = 2'd0,
        CPU_133 = 2'd1,
        CPU_200 = 2'd2,
        CPU_266 = 2'd3
    } cpu_rate_e;

    typedef struct packed {
        logic tbl;
        logic fs_c;
        logic fs_b;
        logic fs_a;
    } strap_t;

    localparam int STRAP_W = $bits(strap_t);
    localparam int RATE_W  = 17;

    localparam logic [RATE_W-1:0] SRC_KHZ = RATE_W'(100000);
    localparam logic [RATE_W-1:0] PCI_KHZ = RATE_W'(33333);
    localparam logic [RATE_W-1:0] REF_KHZ = RATE_W'(14318);
    localparam logic [RATE_W-1:0] USB_KHZ = RATE_W'(48000);

endpackage

// File: rtl/fsel_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous level inputs.
// Assumes: inputs are quasi-static levels, so bits may resolve in
// different cycles without harm. Reset loads RST_VAL into every stage.
module fsel_sync #(
    parameter int           W       = 5,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stg
            logic [W-1:0] r;
            if (i == 0) begin : g_first
                // First stage: sample the raw asynchronous pins
                always_ff @(posedge clk) begin
                    if (!rst_n) r <= RST_VAL;
                    else        r <= d;
                end
            end else begin : g_next
                // Later stages: shift the previous stage along
                always_ff @(posedge clk) begin
                    if (!rst_n) r <= RST_VAL;
                    else        r <= g_stg[i-1].r;
                end
            end
        end
    endgenerate

    assign q = g_stg[STAGES-1].r;

endmodule

// File: rtl/fsel_capture.sv
// One-shot strap capture. It qualifies power-good low over two
// consecutive synchronized samples, freezes the straps on the first
// qualified low and then sets a sticky lock.
// Assumes: pwrgd_s and straps_s come out of the same synchronizer.
module fsel_capture
    import fsel_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pwrgd_s,
    input  strap_t straps_s,
    output strap_t strap_q,
    output logic   locked
);

    logic pg_prev;
    logic valid_low;
    logic take;

    assign valid_low = !pwrgd_s && !pg_prev;
    assign take      = valid_low && !locked;

    // Remember the previous synchronized power-good sample
    always_ff @(posedge clk) begin
        if (!rst_n) pg_prev <= 1'b1;
        else        pg_prev <= pwrgd_s;
    end

    // Freeze the straps on the first qualified low
    always_ff @(posedge clk) begin
        if (!rst_n)    strap_q <= '0;
        else if (take) strap_q <= straps_s;
    end

    // Sticky lock flag, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n)    locked <= 1'b0;
        else if (take) locked <= 1'b1;
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked); // R4

    AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(strap_q)); // R4

    AST_TWO_LOW_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(pwrgd_s, 1) == 1'b0 && $past(pwrgd_s, 2) == 1'b0)); // R2

endmodule

// File: rtl/fsel_decode.sv
// Decodes the frozen straps into a CPU rate code and a reserved flag.
// It uses the three-bit table when the latched table choice is 0 and
// the two-bit table when it is 1. Before lock it drives the default code.
module fsel_decode
    import fsel_pkg::*;
(
    input  strap_t    strap_q,
    input  logic      locked,
    output cpu_rate_e cpu_sel,
    output logic      reserved
);

    cpu_rate_e code3, code2;
    logic      rsv3, rsv2;

    // Three-bit table over {fs_c, fs_b, fs_a}
    always_comb begin
        rsv3  = 1'b0;
        code3 = CPU_100;
        case ({strap_q.fs_c, strap_q.fs_b, strap_q.fs_a})
            3'b101:  code3 = CPU_100;
            3'b001:  code3 = CPU_133;
            3'b010:  code3 = CPU_200;
            3'b000:  code3 = CPU_266;
            default: rsv3  = 1'b1;
        endcase
    end

    // Two-bit table over {fs_b, fs_a}; fs_c is not read
    always_comb begin
        rsv2  = 1'b0;
        code2 = CPU_100;
        case ({strap_q.fs_b, strap_q.fs_a})
            2'b00:   code2 = CPU_100;
            2'b01:   code2 = CPU_133;
            2'b10:   code2 = CPU_200;
            default: rsv2  = 1'b1;
        endcase
    end

    // Pick the table and hold defaults until lock
    always_comb begin
        if (!locked) begin
            cpu_sel  = CPU_100;
            reserved = 1'b0;
        end else if (strap_q.tbl) begin
            cpu_sel  = code2;
            reserved = rsv2;
        end else begin
            cpu_sel  = code3;
            reserved = rsv3;
        end
    end

endmodule

// File: rtl/pwrgd_freq_sel.sv
// Top level of the power-good latched frequency selector. It chains the
// synchronizer, the one-shot capture and the table decode, and drives
// the constant companion rates.
// Assumes: clk runs before power-good falls; rst_n is synchronous.
module pwrgd_freq_sel
    import fsel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwrgd_n,
    input  logic              fs_a,
    input  logic              fs_b,
    input  logic              fs_c,
    input  logic              tbl_sel,
    output logic [1:0]        cpu_sel,
    output logic              cpu_reserved,
    output logic              locked,
    output logic [RATE_W-1:0] src_khz,
    output logic [RATE_W-1:0] pci_khz,
    output logic [RATE_W-1:0] ref_khz,
    output logic [RATE_W-1:0] usb_khz
);

    localparam int BUS_W = STRAP_W + 1;
    localparam logic [BUS_W-1:0] BUS_RST = {1'b1, {STRAP_W{1'b0}}};

    logic [BUS_W-1:0] raw_bus, sync_bus;
    strap_t           straps_s, strap_q;
    logic             pwrgd_s;
    cpu_rate_e        rate;

    assign raw_bus  = {pwrgd_n, tbl_sel, fs_c, fs_b, fs_a};
    assign pwrgd_s  = sync_bus[BUS_W-1];
    assign straps_s = strap_t'(sync_bus[STRAP_W-1:0]);

    fsel_sync #(
        .W      (BUS_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(BUS_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_bus),
        .q    (sync_bus)
    );

    fsel_capture u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwrgd_s (pwrgd_s),
        .straps_s(straps_s),
        .strap_q (strap_q),
        .locked  (locked)
    );

    fsel_decode u_dec (
        .strap_q (strap_q),
        .locked  (locked),
        .cpu_sel (rate),
        .reserved(cpu_reserved)
    );

    assign cpu_sel = rate;
    assign src_khz = SRC_KHZ;
    assign pci_khz = PCI_KHZ;
    assign ref_khz = REF_KHZ;
    assign usb_khz = USB_KHZ;

    AST_IDLE_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> (cpu_sel == 2'd0 && !cpu_reserved)); // R9

    AST_RSV_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_reserved |-> cpu_sel == 2'd0); // R8

    AST_OUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && $past(locked)) |-> ($stable(cpu_sel) && $stable(cpu_reserved))); // R4

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!locked && cpu_sel == 2'd0 && !cpu_reserved)); // R1

endmodule

// File: tb/tb_pwrgd_freq_sel.sv
module tb_pwrgd_freq_sel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwrgd_n = 1'b1;
    logic        fs_a = 1'b0, fs_b = 1'b0, fs_c = 1'b0, tbl_sel = 1'b0;
    logic [1:0]  cpu_sel;
    logic        cpu_reserved, locked;
    logic [16:0] src_khz, pci_khz, ref_khz, usb_khz;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    pwrgd_freq_sel dut (
        .clk(clk), .rst_n(rst_n), .pwrgd_n(pwrgd_n),
        .fs_a(fs_a), .fs_b(fs_b), .fs_c(fs_c), .tbl_sel(tbl_sel),
        .cpu_sel(cpu_sel), .cpu_reserved(cpu_reserved), .locked(locked),
        .src_khz(src_khz), .pci_khz(pci_khz), .ref_khz(ref_khz), .usb_khz(usb_khz)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected decode from the requirement tables
    function automatic void exp_dec(input int t, input int f, output int code, output int rsv);
        rsv = 0; code = 0;
        if (t == 0) begin
            case (f)
                5: code = 0;
                1: code = 1;
                2: code = 2;
                0: code = 3;
                default: rsv = 1;
            endcase
        end else begin
            case (f & 3)
                0: code = 0;
                1: code = 1;
                2: code = 2;
                default: rsv = 1;
            endcase
        end
    endfunction

    task automatic set_straps(input int t, input int f);
        tbl_sel = t[0]; fs_c = f[2]; fs_b = f[1]; fs_a = f[0];
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pwrgd_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic final_report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R3 watchdog: actual=hung expected=finished");
        final_report();
    end

    initial begin
        int code, rsv;
        // R1: reset state, R10 constants
        set_straps(0, 0);
        do_reset();
        chk("R1 locked", locked, 0);
        chk("R1 cpu_sel", cpu_sel, 0);
        chk("R1 reserved", cpu_reserved, 0);
        chk("R10 src", src_khz, 100000);
        chk("R10 pci", pci_khz, 33333);
        chk("R10 ref", ref_khz, 14318);
        chk("R10 usb", usb_khz, 48000);

        // R2: a low sampled at a single edge is ignored
        pwrgd_n = 1'b0;
        @(negedge clk);
        pwrgd_n = 1'b1;
        repeat (8) @(negedge clk);
        chk("R2 single-edge low no lock", locked, 0);
        chk("R9 idle cpu_sel", cpu_sel, 0);

        // R2: a low sampled at exactly two edges locks
        pwrgd_n = 1'b0;
        repeat (2) @(negedge clk);
        pwrgd_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R2 two-edge low locks", locked, 1);
        chk("R6 code for 000", cpu_sel, 3);

        // R3: exact lock timing with straps moving after edge k+1
        set_straps(0, 1);
        do_reset();
        pwrgd_n = 1'b0;
        @(posedge clk); // edge k
        @(posedge clk); // edge k+1
        @(negedge clk);
        set_straps(1, 6); // complement of the captured value
        @(posedge clk); // edge k+2
        @(negedge clk);
        chk("R3 locked after k+2", locked, 0);
        @(posedge clk); // edge k+3
        @(negedge clk);
        chk("R3 locked after k+3", locked, 1);
        chk("R3 captured pre-switch straps", cpu_sel, 1);
        chk("R3 captured reserved", cpu_reserved, 0);

        // R5 R6 R7 R8 R4 R9: sweep of both tables over all selects
        for (int t = 0; t < 2; t++) begin
            for (int f = 0; f < 8; f++) begin
                set_straps(t, f);
                do_reset();
                repeat (3) @(negedge clk);
                chk("R9 before lock cpu_sel", cpu_sel, 0);
                chk("R9 before lock reserved", cpu_reserved, 0);
                pwrgd_n = 1'b0;
                repeat (6) @(negedge clk);
                exp_dec(t, f, code, rsv);
                chk("R3 locked in sweep", locked, 1);
                chk(t == 0 ? "R6 R5 cpu_sel table0" : "R7 R5 cpu_sel table1", cpu_sel, code);
                chk("R8 reserved flag", cpu_reserved, rsv);
                // R4: toggle every input after lock
                set_straps(1 - t, 7 - f);
                pwrgd_n = 1'b1;
                repeat (4) @(negedge clk);
                pwrgd_n = 1'b0;
                repeat (6) @(negedge clk);
                chk("R4 cpu_sel frozen", cpu_sel, code);
                chk("R4 reserved frozen", cpu_reserved, rsv);
                chk("R4 locked held", locked, 1);
                chk("R10 src under lock", src_khz, 100000);
            end
        end

        // R1: reset after lock clears everything
        do_reset();
        chk("R1 relock cleared", locked, 0);
        chk("R1 relock cpu_sel", cpu_sel, 0);
        final_report();
    end

endmodule